// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Register

This block collects event flags for a clock-control peripheral. A vector of level status inputs comes in from oscillators and frequency/phase locked loops: ready, clock-failure, lock, lock-lost, timeout and divider-update indications. Each input is sampled once into a register. A flag is latched when a rising edge of its input is seen, so the flag records that the event happened. The current level of the input does not matter. Software reads the flags from a 32-bit register and clears any of them by writing a 1 to that bit position.

A separate enable mask decides which flags reach the single interrupt request output. The mask has two write addresses. A 1 written to the set address turns a bit on, and a 1 written to the clear address turns a bit off. Both addresses read back the current mask. The request output is registered.

The register bus is a plain single-cycle port with no handshake. Writes take effect on the clock edge where the write enable is high, and reads return combinationally. There is no back-pressure, because every access completes in one cycle.

Top module: `clkint_flags`

## Requirements
- R1: After reset, the flag register, the enable mask and the interrupt output are all 0.
- R2: A flag sets only on a 0-to-1 change of its status input. It reads back 1 on the second clock edge after the input rises, because the input passes through one sample stage and one edge stage. An input that stays high does not set the flag again after it has been cleared.
- R3: Writing 1 to a bit of the flag register at byte offset 0x08 clears that flag. Writing 0 leaves it unchanged.
- R4: A write only affects the bytes whose strobe is high. Strobe bit k covers data bits 8k+7 down to 8k.
- R5: If a rising edge and a write-1 clear reach the same flag on the same clock edge, the flag ends up set.
- R6: Writing 1 to a bit at the enable-set offset 0x04 enables that bit, and writing 1 at the enable-clear offset 0x00 disables it. Writing 0 to either offset has no effect. Both offsets read back the enable mask.
- R7: The interrupt output equals the OR over all bits of (flag AND enable), delayed by one clock after the flag or enable change.
- R8: Only bits 19:16, 12:8, 4, 1 and 0 are implemented. All other bits read 0 and ignore writes. The flag register reads back raw flags whatever the enable mask holds.
- R9: Any offset other than 0x00, 0x04 and 0x08 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes for writes |
| bus_rdata | output | 32 | Read data for bus_addr |
| status_i | input | 32 | Level status inputs, one per flag bit |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong sample or previous-sample stage appears as a flag that sets a cycle early or late, or that sets again while its input is held high. The bench sees this on the first flag read after the input changes. A corrupted flag or enable bit appears as a wrong read value, and one cycle later as a wrong level on the interrupt output, because that output is only one register away from the flag and enable state. The bench sweeps every bit position for flag setting, clearing and enabling. Any miswired or unmasked bit therefore shows up in the read data within two or three cycles of the stimulus.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  // Byte offsets of the three registers
  localparam int unsigned OFF_EN_CLR = 32'h00;
  localparam int unsigned OFF_EN_SET = 32'h04;
  localparam int unsigned OFF_FLAGS  = 32'h08;

  // Bits that carry a real flag: PLL group 19:16, FLL group 12:8, oscillator bits 4,1,0
  localparam logic [31:0] DEFAULT_IMPL = 32'h000F_1F13;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EN_CLR,
    SEL_EN_SET,
    SEL_FLAGS
  } reg_sel_e;
endpackage

// File: rtl/ifr_edge.sv
module ifr_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] smp_q;
  logic [W-1:0] prv_q;

  // one sample stage, then the previous sample for edge comparison
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      prv_q <= '0;
    end else begin
      smp_q <= lvl_i;
      prv_q <= smp_q;
    end
  end

  assign rise_o = smp_q & ~prv_q;
endmodule

// File: rtl/ifr_flags.sv
module ifr_flags #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  // a set on the same edge as a clear takes priority
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= ((flag_q & ~clr_i) | rise_i) & MASK;
  end

  assign flag_o = flag_q;

  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i != '0) |=> ((flag_q & $past(rise_i & MASK)) == $past(rise_i & MASK)));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_i & clr_i & MASK) != '0) |=>
      ((flag_q & $past(rise_i & clr_i & MASK)) == $past(rise_i & clr_i & MASK)));

  assert_clear_needs_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != '0) |=> ((~flag_q & $past(flag_q) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/ifr_enable.sv
module ifr_enable #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= ((en_q & ~clr_i) | set_i) & MASK;
  end

  assign en_o = en_q;

  assert_enable_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & MASK) != '0) |=> ((en_q & $past(set_i & MASK)) == $past(set_i & MASK)));

  assert_enable_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((clr_i & MASK) != '0) && (set_i == '0)) |=> ((en_q & $past(clr_i & MASK)) == '0));
endmodule

// File: rtl/clkint_flags.sv
module clkint_flags
  import ifr_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 8,
  parameter logic [DATA_W-1:0] IMPL_MASK = DEFAULT_IMPL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] status_i,
  output logic              irq_o
);
  localparam int NB = DATA_W / 8;

  reg_sel_e          sel;
  logic [DATA_W-1:0] byte_mask;
  logic [DATA_W-1:0] wr_bits;
  logic [DATA_W-1:0] rise;
  logic [DATA_W-1:0] flags;
  logic [DATA_W-1:0] en;
  logic [DATA_W-1:0] flag_clr;
  logic [DATA_W-1:0] en_set;
  logic [DATA_W-1:0] en_clr;
  logic              irq_q;

  // address decode
  always_comb begin
    if      (bus_addr == ADDR_W'(OFF_FLAGS))  sel = SEL_FLAGS;
    else if (bus_addr == ADDR_W'(OFF_EN_SET)) sel = SEL_EN_SET;
    else if (bus_addr == ADDR_W'(OFF_EN_CLR)) sel = SEL_EN_CLR;
    else                                      sel = SEL_NONE;
  end

  // byte strobes widened to a bit mask
  for (genvar b = 0; b < NB; b++) begin : g_be
    assign byte_mask[b*8 +: 8] = {8{bus_be[b]}};
  end

  assign wr_bits  = bus_wdata & byte_mask;
  assign flag_clr = (bus_we && sel == SEL_FLAGS)  ? wr_bits : '0;
  assign en_set   = (bus_we && sel == SEL_EN_SET) ? wr_bits : '0;
  assign en_clr   = (bus_we && sel == SEL_EN_CLR) ? wr_bits : '0;

  ifr_edge #(.W(DATA_W)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (status_i),
    .rise_o (rise)
  );

  ifr_flags #(.W(DATA_W), .MASK(IMPL_MASK)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (rise),
    .clr_i  (flag_clr),
    .flag_o (flags)
  );

  ifr_enable #(.W(DATA_W), .MASK(IMPL_MASK)) u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (en_set),
    .clr_i (en_clr),
    .en_o  (en)
  );

  // read mux
  always_comb begin
    case (sel)
      SEL_FLAGS:             bus_rdata = flags;
      SEL_EN_SET, SEL_EN_CLR: bus_rdata = en;
      default:               bus_rdata = '0;
    endcase
  end

  // registered interrupt request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(flags & en);
  end

  assign irq_o = irq_q;

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past((flags & en) != '0));

  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past((flags & en) == '0));

  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/clkint_flags_test.sv
`timescale 1ns/1ps
module clkint_flags_test;
  localparam logic [31:0] IMPL   = 32'h000F_1F13;
  localparam logic [7:0]  A_ECLR = 8'h00;
  localparam logic [7:0]  A_ESET = 8'h04;
  localparam logic [7:0]  A_FLAG = 8'h08;
  localparam logic [7:0]  A_NONE = 8'h0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [31:0] status = '0;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] v;

  always #4 clk = ~clk;

  clkint_flags uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .status_i  (status),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] r);
    bus_addr = a;
    #1;
    r = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset state
    rd(A_FLAG, v); chk("R1 flags", v, 32'h0);
    rd(A_ESET, v); chk("R1 enable", v, 32'h0);
    rd(A_ECLR, v); chk("R1 enable via clr", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2/R3/R8: per-bit set, clear, held-high sweep
    for (int i = 0; i < 32; i++) begin
      status = 32'h1 << i;
      step(2);
      rd(A_FLAG, v); chk("R2/R8 rising edge sets flag", v, IMPL & (32'h1 << i));
      wr(A_FLAG, 32'hFFFF_FFFF, 4'hF);
      rd(A_FLAG, v); chk("R3 write one clears", v, 32'h0);
      step(3);
      rd(A_FLAG, v); chk("R2 held high no re-set", v, 32'h0);
      status = '0;
      step(2);
    end

    // R3 write zero no effect, R4 byte strobes
    status = 32'hFFFF_FFFF;
    step(2);
    rd(A_FLAG, v); chk("R8 only implemented bits", v, IMPL);
    wr(A_FLAG, 32'h0, 4'hF);
    rd(A_FLAG, v); chk("R3 write zero no effect", v, IMPL);
    wr(A_FLAG, 32'hFFFF_FFFF, 4'b0010);
    rd(A_FLAG, v); chk("R4 strobe byte1 only", v, IMPL & ~32'h0000_FF00);
    wr(A_FLAG, 32'hFFFF_FFFF, 4'b1101);
    rd(A_FLAG, v); chk("R4 remaining bytes", v, 32'h0);
    status = '0;
    step(2);

    // R9 unmapped offset
    status = 32'hFFFF_FFFF;
    step(2);
    status = '0;
    wr(A_NONE, 32'hFFFF_FFFF, 4'hF);
    rd(A_FLAG, v); chk("R9 flags untouched", v, IMPL);
    rd(A_ESET, v); chk("R9 enable untouched", v, 32'h0);
    rd(A_NONE, v); chk("R9 unmapped reads zero", v, 32'h0);
    step(2);

    // R7/R6: per-bit enable sweep with all flags set
    for (int j = 0; j < 32; j++) begin
      wr(A_ESET, 32'h1 << j, 4'hF);
      chk("R7 irq registered", {31'h0, irq}, 32'h0);
      step(1);
      chk("R7 irq follows flag and enable", {31'h0, irq}, {31'h0, IMPL[j]});
      rd(A_ESET, v); chk("R6 set readback", v, IMPL & (32'h1 << j));
      rd(A_ECLR, v); chk("R6 clr readback", v, IMPL & (32'h1 << j));
      wr(A_ECLR, 32'h1 << j, 4'hF);
      step(1);
      chk("R7 irq off after disable", {31'h0, irq}, 32'h0);
    end

    // R6 set/clear semantics
    wr(A_ESET, 32'hFFFF_FFFF, 4'hF);
    rd(A_ESET, v); chk("R6 enable all", v, IMPL);
    wr(A_ESET, 32'h0, 4'hF);
    rd(A_ECLR, v); chk("R6 write zero no effect", v, IMPL);
    wr(A_ECLR, 32'h0001_0001, 4'hF);
    rd(A_ESET, v); chk("R6 clear bits", v, IMPL & ~32'h0001_0001);
    wr(A_ECLR, 32'hFFFF_FFFF, 4'b0100);
    rd(A_ESET, v); chk("R4 strobe on enable clear", v, IMPL & ~32'h00FF_0001);
    rd(A_FLAG, v); chk("R8 raw flags regardless of enable", v, IMPL);
    step(1);
    chk("R7 irq with enabled flags", {31'h0, irq}, 32'h1);
    wr(A_FLAG, 32'hFFFF_FFFF, 4'hF);
    chk("R7 irq holds one cycle", {31'h0, irq}, 32'h1);
    step(1);
    chk("R7 irq drops after clear", {31'h0, irq}, 32'h0);

    // R5 set wins over same-cycle clear
    status = 32'h1;
    step(2);
    rd(A_FLAG, v); chk("R2 flag0 set", v, 32'h1);
    status = '0;
    step(2);
    status = 32'h1;
    step(1);
    wr(A_FLAG, 32'h1, 4'hF);
    rd(A_FLAG, v); chk("R5 set wins", v, 32'h1);
    wr(A_FLAG, 32'h1, 4'hF);
    rd(A_FLAG, v); chk("R3 clear without edge", v, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R1-timeout actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule